// File: doc/BRIEF.md
# Set-Dueling Inclusion Policy Selector

This block decides, at run time, whether a last-level cache should behave non-inclusively or exclusively towards the private caches above it. A small number of LLC sets are reserved as samples. One group always runs non-inclusive and the other always runs exclusive. Every other set is a follower and takes whichever policy is currently winning. For each LLC access the block is given the issuing core, the set index, a miss flag and an insertion flag. It returns the class of that set and the policy the set must use in the same cycle.

For each core the block keeps four saturating counters: misses and insertions for each of the two sample groups. An epoch ends after a programmable number of valid accesses. At that point the block compares the miss difference against a performance threshold to pick the mode. It compares the insertion difference against a traffic threshold to pick a sub-mode: bypass when the mode is exclusive, aggressive when it is non-inclusive. All counters are then halved so that old behaviour fades. The cache arrays and the fill and victim paths that act on these outputs are outside this block.

Top module: `incl_policy_sel`

## Requirements
- R1: After reset, every core's mode bit (1 = exclusive, 0 = non-inclusive) is 0, and its aggressive and bypass flags are 0. They stay so until the first epoch closes.
- R2: `set_class_o` is 1 when the set index modulo 32 equals 0 (non-inclusive sample), 2 when it equals 1 (exclusive sample), and 0 otherwise (follower). It is combinational from `acc_set`.
- R3: `set_policy_o` is 0 for a non-inclusive sample set and 1 for an exclusive sample set, whatever the mode. For a follower set it equals the mode bit of the core on `acc_core`.
- R4: Each sample counter is 16 bits wide and saturates at 65535 instead of wrapping.
- R5: At an epoch close, a core's mode becomes 1 only if (non-inclusive sample misses − exclusive sample misses), taken as a signed value, is strictly greater than `perf_thr`. Otherwise it becomes 0. A negative or equal difference gives 0.
- R6: At the same epoch close, the insertion test is (exclusive sample insertions − non-inclusive sample insertions) > `ins_thr`, signed and strict. If the test holds, bypass is set when the new mode is 1 and aggressive is set when it is 0. At most one flag is set per core.
- R7: Each core's counters count only accesses whose `acc_core` names that core, so each core decides independently.
- R8: An epoch closes on the valid access that brings the count of valid accesses since the previous close up to `epoch_len`. The decision made at that access appears one cycle later. Mode and flags hold their values at every other time.
- R9: The decision at an epoch close uses the counter values accumulated so far. All counters are then halved, and the closing access's own increment is added to the halved value.
- R10: Accesses to follower sets, and cycles with `acc_valid` low, change no sample counter. `acc_valid` low also does not advance the epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An LLC access is present this cycle |
| acc_core | input | 1 | Core issuing the access (CORE_W) |
| acc_set | input | 10 | LLC set index of the access |
| acc_miss | input | 1 | The access missed in the LLC |
| acc_ins | input | 1 | The access inserted a line into the LLC |
| epoch_len | input | 20 | Valid accesses per epoch |
| perf_thr | input | 16 | Miss-difference threshold for the mode |
| ins_thr | input | 16 | Insertion-difference threshold for the sub-mode |
| set_class_o | output | 2 | Class of `acc_set`: 0 follower, 1 non-inclusive sample, 2 exclusive sample |
| set_policy_o | output | 1 | Policy for this access: 1 exclusive, 0 non-inclusive |
| mode_o | output | 2 | Per-core mode bit (NUM_CORES) |
| aggr_o | output | 2 | Per-core aggressive non-inclusive flag |
| bypass_o | output | 2 | Per-core exclusive bypass flag |

## Verification
None of the counters are visible at the ports. A wrong count shows up only as a wrong mode or flag in the cycle after the next epoch close, or in a later epoch, because halving carries a corrupted value forward for several epochs. The bench therefore sets up epochs whose outcome depends on one specific fault: a wrapped counter, an unsigned compare, a missing halving, or a follower access that was counted. It also compares the set class and the follower policy with a reference model on every access, so a stale mode shows up in the very access that uses it.

// File: rtl/incl_sel_pkg.sv
package incl_sel_pkg;

    typedef enum logic [1:0] {
        CLS_FOLLOW = 2'd0,
        CLS_NI     = 2'd1,
        CLS_EX     = 2'd2
    } set_cls_e;

    typedef struct packed {
        logic mode;
        logic aggr;
        logic bypass;
    } pol_dec_t;

    // slot order inside one core's counter bank
    localparam int SLOT_MISS_NI = 0;
    localparam int SLOT_MISS_EX = 1;
    localparam int SLOT_INS_NI  = 2;
    localparam int SLOT_INS_EX  = 3;
    localparam int NUM_SLOTS    = 4;

    function automatic set_cls_e classify(input int unsigned low_bits,
                                          input int unsigned ni_code,
                                          input int unsigned ex_code);
        if (low_bits == ni_code)      return CLS_NI;
        else if (low_bits == ex_code) return CLS_EX;
        else                          return CLS_FOLLOW;
    endfunction

endpackage

// File: rtl/set_classifier.sv
module set_classifier
    import incl_sel_pkg::*;
#(
    parameter int SET_W   = 10,
    parameter int SMP_W   = 5,
    parameter int NI_CODE = 0,
    parameter int EX_CODE = 1
) (
    input  logic [SET_W-1:0] set_idx,
    output set_cls_e         cls
);
    logic [SMP_W-1:0] low_bits;

    assign low_bits = set_idx[SMP_W-1:0];

    always_comb begin
        cls = classify(32'(low_bits), NI_CODE, EX_CODE);
    end
endmodule

// File: rtl/epoch_timer.sv
module epoch_timer #(
    parameter int EPOCH_W = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [EPOCH_W-1:0] epoch_len,
    output logic               close
);
    logic [EPOCH_W-1:0] seen_q;
    logic [EPOCH_W-1:0] seen_nxt;

    assign seen_nxt = seen_q + 1'b1;
    assign close    = tick && (seen_nxt == epoch_len);

    always_ff @(posedge clk) begin
        if (rst)       seen_q <= '0;
        else if (tick) seen_q <= close ? '0 : seen_nxt;
    end
endmodule

// File: rtl/sample_counters.sv
module sample_counters
    import incl_sel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              close,
    input  logic [NUM_SLOTS-1:0]              bump,
    output logic [NUM_SLOTS-1:0][CNT_W-1:0]   cnt
);
    function automatic logic [CNT_W-1:0] age_and_bump(input logic [CNT_W-1:0] v,
                                                      input logic age,
                                                      input logic inc);
        logic [CNT_W-1:0] base;
        base = age ? (v >> 1) : v;
        return (inc && (base != '1)) ? base + 1'b1 : base;
    endfunction

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [CNT_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) val_q <= '0;
            else     val_q <= age_and_bump(val_q, close, bump[s]);
        end

        assign cnt[s] = val_q;
    end
endmodule

// File: rtl/policy_decider.sv
module policy_decider
    import incl_sel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             close,
    input  logic [CNT_W-1:0] miss_ni,
    input  logic [CNT_W-1:0] miss_ex,
    input  logic [CNT_W-1:0] ins_ni,
    input  logic [CNT_W-1:0] ins_ex,
    input  logic [CNT_W-1:0] perf_thr,
    input  logic [CNT_W-1:0] ins_thr,
    output pol_dec_t         dec
);
    localparam int DW = CNT_W + 2;

    logic signed [DW-1:0] miss_gap;
    logic signed [DW-1:0] ins_gap;
    logic                 go_excl;
    logic                 cut_traffic;
    pol_dec_t             dec_q;

    assign miss_gap    = $signed({2'b00, miss_ni}) - $signed({2'b00, miss_ex});
    assign ins_gap     = $signed({2'b00, ins_ex})  - $signed({2'b00, ins_ni});
    assign go_excl     = miss_gap > $signed({2'b00, perf_thr});
    assign cut_traffic = ins_gap  > $signed({2'b00, ins_thr});

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else if (close) begin
            dec_q.mode   <= go_excl;
            dec_q.bypass <= go_excl && cut_traffic;
            dec_q.aggr   <= !go_excl && cut_traffic;
        end
    end

    assign dec = dec_q;
endmodule

// File: rtl/incl_policy_sel.sv
module incl_policy_sel
    import incl_sel_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int SET_W     = 10,
    parameter int SMP_W     = 5,
    parameter int NI_CODE   = 0,
    parameter int EX_CODE   = 1,
    parameter int CNT_W     = 16,
    parameter int EPOCH_W   = 20,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic [CORE_W-1:0]    acc_core,
    input  logic [SET_W-1:0]     acc_set,
    input  logic                 acc_miss,
    input  logic                 acc_ins,
    input  logic [EPOCH_W-1:0]   epoch_len,
    input  logic [CNT_W-1:0]     perf_thr,
    input  logic [CNT_W-1:0]     ins_thr,
    output logic [1:0]           set_class_o,
    output logic                 set_policy_o,
    output logic [NUM_CORES-1:0] mode_o,
    output logic [NUM_CORES-1:0] aggr_o,
    output logic [NUM_CORES-1:0] bypass_o
);
    set_cls_e                    cls;
    logic                        epoch_close;
    logic [NUM_CORES-1:0][CNT_W-1:0] mni_all;
    logic [NUM_CORES-1:0][CNT_W-1:0] mex_all;

    set_classifier #(
        .SET_W(SET_W), .SMP_W(SMP_W), .NI_CODE(NI_CODE), .EX_CODE(EX_CODE)
    ) u_cls (
        .set_idx(acc_set),
        .cls    (cls)
    );

    epoch_timer #(.EPOCH_W(EPOCH_W)) u_epoch (
        .clk      (clk),
        .rst      (rst),
        .tick     (acc_valid),
        .epoch_len(epoch_len),
        .close    (epoch_close)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic                              mine;
        logic [NUM_SLOTS-1:0]              bump;
        logic [NUM_SLOTS-1:0][CNT_W-1:0]   cnt;
        pol_dec_t                          dec;

        assign mine = acc_valid && (acc_core == CORE_W'(c));

        always_comb begin
            bump               = '0;
            bump[SLOT_MISS_NI] = mine && (cls == CLS_NI) && acc_miss;
            bump[SLOT_MISS_EX] = mine && (cls == CLS_EX) && acc_miss;
            bump[SLOT_INS_NI]  = mine && (cls == CLS_NI) && acc_ins;
            bump[SLOT_INS_EX]  = mine && (cls == CLS_EX) && acc_ins;
        end

        sample_counters #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .close(epoch_close),
            .bump (bump),
            .cnt  (cnt)
        );

        policy_decider #(.CNT_W(CNT_W)) u_dec (
            .clk     (clk),
            .rst     (rst),
            .close   (epoch_close),
            .miss_ni (cnt[SLOT_MISS_NI]),
            .miss_ex (cnt[SLOT_MISS_EX]),
            .ins_ni  (cnt[SLOT_INS_NI]),
            .ins_ex  (cnt[SLOT_INS_EX]),
            .perf_thr(perf_thr),
            .ins_thr (ins_thr),
            .dec     (dec)
        );

        assign mode_o[c]   = dec.mode;
        assign aggr_o[c]   = dec.aggr;
        assign bypass_o[c] = dec.bypass;
        assign mni_all[c]  = cnt[SLOT_MISS_NI];
        assign mex_all[c]  = cnt[SLOT_MISS_EX];
    end

    assign set_class_o = cls;

    always_comb begin
        unique case (cls)
            CLS_NI:  set_policy_o = 1'b0;
            CLS_EX:  set_policy_o = 1'b1;
            default: set_policy_o = mode_o[acc_core];
        endcase
    end
endmodule

// File: rtl/incl_policy_sel_chk.sv
module incl_policy_sel_chk #(
    parameter int NUM_CORES = 2,
    parameter int CNT_W     = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           epoch_close,
    input logic [NUM_CORES-1:0]           mode_o,
    input logic [NUM_CORES-1:0]           aggr_o,
    input logic [NUM_CORES-1:0]           bypass_o,
    input logic [NUM_CORES-1:0][CNT_W-1:0] mni_all,
    input logic [NUM_CORES-1:0][CNT_W-1:0] mex_all
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (mode_o == '0 && aggr_o == '0 && bypass_o == '0)
                else $error("R1 outputs not clear after reset");
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        a_r6_flag_region: assert property (@(posedge clk) disable iff (rst)
            (!bypass_o[c] || mode_o[c]) && (!aggr_o[c] || !mode_o[c]))
            else $error("R6 sub-mode flag outside its region");

        a_r8_hold_off_epoch: assert property (@(posedge clk) disable iff (rst)
            !epoch_close |=> $stable(mode_o[c]) && $stable(aggr_o[c]) && $stable(bypass_o[c]))
            else $error("R8 decision moved without epoch close");

        a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
            !epoch_close |=> (mni_all[c] >= $past(mni_all[c])))
            else $error("R4 miss counter wrapped");

        a_r5_no_excl_when_equal: assert property (@(posedge clk) disable iff (rst)
            epoch_close && (mni_all[c] <= mex_all[c]) |=> !mode_o[c])
            else $error("R5 exclusive chosen without miss advantage");
    end
endmodule

bind incl_policy_sel incl_policy_sel_chk #(
    .NUM_CORES(NUM_CORES),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .epoch_close(epoch_close),
    .mode_o     (mode_o),
    .aggr_o     (aggr_o),
    .bypass_o   (bypass_o),
    .mni_all    (mni_all),
    .mex_all    (mex_all)
);

// File: tb/incl_policy_sel_bench.sv
`timescale 1ns/1ps
module incl_policy_sel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [0:0]  acc_core = '0;
    logic [9:0]  acc_set = '0;
    logic        acc_miss = 1'b0;
    logic        acc_ins = 1'b0;
    logic [19:0] epoch_len = 20'd1000;
    logic [15:0] perf_thr = '0;
    logic [15:0] ins_thr = '0;
    logic [1:0]  set_class_o;
    logic        set_policy_o;
    logic [1:0]  mode_o, aggr_o, bypass_o;

    always #10 clk = ~clk;

    incl_policy_sel u_incl_policy_sel (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_core(acc_core),
        .acc_set(acc_set), .acc_miss(acc_miss), .acc_ins(acc_ins),
        .epoch_len(epoch_len), .perf_thr(perf_thr), .ins_thr(ins_thr),
        .set_class_o(set_class_o), .set_policy_o(set_policy_o),
        .mode_o(mode_o), .aggr_o(aggr_o), .bypass_o(bypass_o)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    int mni[2], mex[2], ini[2], iex[2];
    bit emode[2], eaggr[2], ebyp[2];
    int ecnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails < 20) $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cls_of(input int s);
        int m = s % 32;
        return (m == 0) ? 1 : ((m == 1) ? 2 : 0);
    endfunction

    function automatic int sat(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic check_regs();
        int em = {30'd0, emode[1], emode[0]};
        int ea = {30'd0, eaggr[1], eaggr[0]};
        int eb = {30'd0, ebyp[1], ebyp[0]};
        chk(mode_o == em[1:0], "R5 R7 R8 mode", mode_o, em);
        chk(aggr_o == ea[1:0] && bypass_o == eb[1:0], "R6 R8 flags",
            {aggr_o, bypass_o}, {ea[1:0], eb[1:0]});
    endtask

    task automatic model_step(input int core, input int s, input bit v, input bit miss, input bit ins);
        int c = cls_of(s);
        int nxt;
        if (!v) return;  // R10: no effect when not valid
        nxt = (ecnt + 1) % (1 << 20);
        if (nxt == int'(epoch_len)) begin
            for (int k = 0; k < 2; k++) begin
                bit x = (mni[k] - mex[k]) > int'(perf_thr);
                bit t = (iex[k] - ini[k]) > int'(ins_thr);
                emode[k] = x; ebyp[k] = x && t; eaggr[k] = !x && t;
                mni[k] = mni[k] / 2; mex[k] = mex[k] / 2;
                ini[k] = ini[k] / 2; iex[k] = iex[k] / 2;
            end
            ecnt = 0;
        end else begin
            ecnt = nxt;
        end
        if (c == 1) begin
            if (miss) mni[core] = sat(mni[core] + 1);
            if (ins)  ini[core] = sat(ini[core] + 1);
        end else if (c == 2) begin
            if (miss) mex[core] = sat(mex[core] + 1);
            if (ins)  iex[core] = sat(iex[core] + 1);
        end
    endtask

    task automatic acc(input int core, input int s, input bit v, input bit miss, input bit ins);
        int ec, ep;
        @(negedge clk);
        check_regs();
        acc_valid = v; acc_core = core[0:0]; acc_set = s[9:0];
        acc_miss = miss; acc_ins = ins;
        #1;
        ec = cls_of(s);
        ep = (ec == 1) ? 0 : ((ec == 2) ? 1 : int'(emode[core]));
        chk(set_class_o == ec[1:0], "R2 class", set_class_o, ec);
        chk(set_policy_o == ep[0], "R3 policy", set_policy_o, ep);
        @(posedge clk);
        model_step(core, s, v, miss, ins);
    endtask

    task automatic settle();
        @(negedge clk);
        acc_valid = 1'b0; acc_miss = 1'b0; acc_ins = 1'b0;
        check_regs();
    endtask

    task automatic rep(input int n, input int core, input int s, input bit miss, input bit ins);
        for (int i = 0; i < n; i++) acc(core, s + 32 * (i % 8), 1'b1, miss, ins);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        chk(mode_o == 2'b00 && aggr_o == 2'b00 && bypass_o == 2'b00, "R1 reset",
            {mode_o, aggr_o, bypass_o}, 0);

        // R2/R3 sweep with valid low (no counting, R10)
        for (int s = 0; s < 70; s++) acc(s % 2, s, 1'b0, 1'b1, 1'b1);

        // Epoch B: exclusive wins with bypass on core 0
        epoch_len = 20'd16; perf_thr = 16'd3; ins_thr = 16'd2;
        rep(6, 0, 0, 1'b1, 1'b0);
        rep(1, 0, 1, 1'b1, 1'b0);
        rep(4, 0, 1, 1'b0, 1'b1);
        rep(5, 0, 5, 1'b1, 1'b1);
        settle();
        chk(mode_o == 2'b01, "R5 exclusive chosen", mode_o, 1);
        chk(bypass_o == 2'b01 && aggr_o == 2'b00, "R6 bypass", {aggr_o, bypass_o}, 1);
        for (int s = 2; s < 6; s++) acc(0, s, 1'b0, 1'b0, 1'b0);  // R3 followers see core 0 exclusive
        acc(1, 7, 1'b0, 1'b0, 1'b0);

        // Epoch C: aged counters (R9), followers do not count (R10)
        perf_thr = 16'd4; ins_thr = 16'd100;
        rep(16, 1, 7, 1'b1, 1'b1);
        settle();
        chk(mode_o[0] == 1'b0, "R9 halving lowers gap to 3", mode_o[0], 0);
        chk(mode_o[1] == 1'b0, "R10 follower misses ignored", mode_o[1], 0);

        // Epoch D: aggressive non-inclusive on core 1 (R6, R7)
        perf_thr = 16'd10; ins_thr = 16'd1;
        rep(5, 1, 1, 1'b0, 1'b1);
        rep(2, 1, 0, 1'b1, 1'b0);
        rep(9, 0, 9, 1'b0, 1'b0);
        settle();
        chk(aggr_o == 2'b10 && bypass_o == 2'b00, "R6 aggressive core1", {aggr_o, bypass_o}, 8);
        chk(mode_o == 2'b00, "R7 independent modes", mode_o, 0);

        // Epoch E: equal gap and negative gap both give non-inclusive (R5)
        perf_thr = 16'd0; ins_thr = 16'd0;
        rep(4, 0, 0, 1'b1, 1'b0);
        rep(4, 0, 1, 1'b1, 1'b0);
        rep(3, 1, 1, 1'b1, 1'b0);
        rep(5, 0, 3, 1'b0, 1'b0);
        settle();
        chk(mode_o == 2'b00, "R5 equal and negative gap", mode_o, 0);

        // Epoch F: saturation (R4)
        epoch_len = 20'd70010; perf_thr = 16'd65530; ins_thr = 16'hFFFF;
        rep(70000, 0, 0, 1'b1, 1'b0);
        rep(9, 1, 4, 1'b0, 1'b0);
        chk(mode_o[0] == 1'b0, "R8 no change before close", mode_o[0], 0);
        rep(1, 1, 4, 1'b0, 1'b0);
        settle();
        chk(mode_o[0] == 1'b1, "R4 saturated counter wins", mode_o[0], 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule